// File: doc/BRIEF.md
# UART Receive Character Buffer

This block sits between the serial receiver of a memory-mapped UART and its register interface. The receiver hands over a character, or a break indication, together with a push strobe. The buffer stores each accepted item as an 11-bit entry in a 16-slot circular store. The register side pops entries out one at a time through the data-register read path. The block also reports an occupancy count to the interrupt logic, a ready signal back to the receiver, and the receive-side bits of the flag byte.

A line-control input picks between two modes. With buffering on, the full 16-slot store is used. With buffering off, the block behaves as a single holding register and takes a new character only when nothing is waiting. A pop on an empty buffer is harmless: it returns whatever entry sits at the read position and moves nothing.

Top module: `rx_char_buffer`

## Requirements
- R1: Out of reset, `flag_word` is 0x90: bit 7 (transmit side empty, always 1 here) and bit 4 (receive empty) are set and every other bit is clear. `level` is 0 and `push_ready` is 1.
- R2: With `fifo_en` high, `push_ready` is high while `level` is below 16. A push is accepted whenever `push_ready` is high.
- R3: With `fifo_en` low, `push_ready` is high only while `level` is 0, so at most one entry is taken in.
- R4: Entries pop out in the order they were accepted, including when the read position wraps from slot 15 back to slot 0.
- R5: A push with `push_break` high stores the entry 0x400: bit 10 is set and the data bits are zero. The value of `push_data` is ignored for that push.
- R6: A push with `push_break` low stores `push_data` in bits 7:0, with bits 10:8 zero.
- R7: Receive-empty (flag bit 4) is cleared by an accepted push. It is set when a pop leaves `level` at 0.
- R8: Receive-full (flag bit 6) is set when `level` reaches 16. It is cleared by any pop.
- R9: `pop_data` always shows the entry at the read position, during the cycle `pop_req` is high. A pop while `level` is 0 returns that stale entry and leaves `level` and the read position unchanged. After reset, every slot holds 0.
- R10: A push and a pop in the same cycle are both honoured: `level` is unchanged, and the flags follow the resulting count.
- R11: A push attempted while `push_ready` is low is dropped. `level` and all stored entries are unchanged.
- R12: `level` gives the number of stored entries. It changes by +1 for an accepted push alone and by -1 for a pop of a non-empty buffer alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | Line-control buffering enable: 1 = 16-entry mode, 0 = single holding register |
| push_valid | input | 1 | Receiver offers an item this cycle |
| push_break | input | 1 | The offered item is a break event |
| push_data | input | 8 | Received character |
| push_ready | output | 1 | Buffer can accept a push this cycle |
| pop_req | input | 1 | Data-register read consumes the head entry |
| pop_data | output | 11 | Entry at the read position |
| level | output | 5 | Stored entry count, 0 to 16 |
| flag_word | output | 8 | Flag byte: bit 7 transmit-empty (1), bit 6 receive-full, bit 4 receive-empty |

## Verification
A corrupted count or read position shows up at the ports in the same cycle: `push_ready`, `level` and the flag bits are all driven straight from those registers. A wrong write slot or a lost store stays hidden until that slot reaches the head of the buffer. That can take up to 16 pops, so the bench fills the store completely, wraps it, and compares every popped entry against an ordered scoreboard. Stale reads on empty pops also expose any slot that was written when it should not have been.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

    // Width of one stored entry: data byte plus status bits up to the break bit
    localparam int ENTRY_W = 11;
    // Position of the break marker inside an entry
    localparam int BRK_BIT = 10;

    // Flag byte bit positions, decoded by the register block
    localparam int FLG_TX_EMPTY = 7;
    localparam int FLG_RX_FULL  = 6;
    localparam int FLG_RX_EMPTY = 4;

    typedef logic [ENTRY_W-1:0] entry_t;

    // Build a stored entry from a receiver push
    function automatic entry_t make_entry(input logic is_brk, input logic [7:0] ch);
        entry_t e;
        e = '0;
        if (is_brk) begin
            e[BRK_BIT] = 1'b1;
        end else begin
            e[7:0] = ch;
        end
        return e;
    endfunction

endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int EW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [EW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [EW-1:0] rd_data
);

    logic [DEPTH-1:0][EW-1:0] slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (wr_en) begin
            slot_d[wr_addr] = wr_data;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q[gi] <= '0;
                end else begin
                    slot_q[gi] <= slot_d[gi];
                end
            end
        end
    endgenerate

    assign rd_data = slot_q[rd_addr];

    // R11
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(slot_q));

    // R6
    store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> slot_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          push_ok,
    output logic          accept,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] count,
    output logic          rx_empty,
    output logic          rx_full
);

    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          empty;
        logic          full;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  pop_move;
    logic [CW:0] slot_sum;

    always_comb begin
        push_ok  = fifo_en ? (st_q.cnt < CNT_MAX) : (st_q.cnt == '0);
        accept   = push_req && push_ok;
        pop_move = pop_req && (st_q.cnt != '0);

        slot_sum = {{(CW+1-AW){1'b0}}, st_q.rd} + {1'b0, st_q.cnt};
        if (slot_sum >= (CW+1)'(DEPTH)) begin
            slot_sum = slot_sum - (CW+1)'(DEPTH);
        end
        wr_addr = slot_sum[AW-1:0];

        st_d = st_q;
        if (pop_move) begin
            st_d.rd = (st_q.rd == PTR_LAST) ? '0 : st_q.rd + AW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(accept) - CW'(pop_move);

        if (accept) begin
            st_d.empty = 1'b0;
            if (st_d.cnt == CNT_MAX) begin
                st_d.full = 1'b1;
            end
        end
        if (pop_req) begin
            st_d.full = 1'b0;
            if (st_d.cnt == '0) begin
                st_d.empty = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rd: '0, cnt: '0, empty: 1'b1, full: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr  = st_q.rd;
    assign count    = st_q.cnt;
    assign rx_empty = st_q.empty;
    assign rx_full  = st_q.full;

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);

    // R8
    full_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full == (st_q.cnt == CNT_MAX));

    // R7
    empty_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.empty == (st_q.cnt == '0));

    // R9
    stale_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && st_q.cnt == '0 && !push_req) |=> ($stable(st_q.rd) && st_q.cnt == '0));

    // R10
    both_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pop_move) |=> $stable(st_q.cnt));

    // R3
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !$past(fifo_en) && $past(rst_n) && st_q.cnt > CW'(1)) |-> $past(st_q.cnt) > CW'(1));

endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer #(
    parameter int DEPTH  = 16,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fifo_en,
    input  logic                        push_valid,
    input  logic                        push_break,
    input  logic [7:0]                  push_data,
    output logic                        push_ready,
    input  logic                        pop_req,
    output logic [rxbuf_pkg::ENTRY_W-1:0] pop_data,
    output logic [LVL_W-1:0]            level,
    output logic [7:0]                  flag_word
);
    import rxbuf_pkg::*;

    logic          accept;
    logic [PTR_W-1:0] wr_addr, rd_addr;
    logic          rx_empty, rx_full;
    entry_t        new_entry;

    assign new_entry = make_entry(push_break, push_data);

    rxbuf_ctrl #(.DEPTH(DEPTH), .AW(PTR_W), .CW(LVL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .push_req (push_valid),
        .pop_req  (pop_req),
        .push_ok  (push_ready),
        .accept   (accept),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .count    (level),
        .rx_empty (rx_empty),
        .rx_full  (rx_full)
    );

    rxbuf_store #(.DEPTH(DEPTH), .AW(PTR_W), .EW(ENTRY_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_addr (wr_addr),
        .wr_data (new_entry),
        .rd_addr (rd_addr),
        .rd_data (pop_data)
    );

    always_comb begin
        flag_word               = '0;
        flag_word[FLG_TX_EMPTY] = 1'b1;
        flag_word[FLG_RX_FULL]  = rx_full;
        flag_word[FLG_RX_EMPTY] = rx_empty;
    end

endmodule

// File: tb/rx_char_buffer_tb.sv
module rx_char_buffer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b1;
    logic        push_valid = 1'b0;
    logic        push_break = 1'b0;
    logic [7:0]  push_data = '0;
    logic        push_ready;
    logic        pop_req = 1'b0;
    logic [10:0] pop_data;
    logic [4:0]  level;
    logic [7:0]  flag_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state built from the requirements
    logic [10:0] sb_q[$];
    logic [10:0] ref_slot [16];
    int          ref_rd = 0;

    always #4 clk = ~clk;

    rx_char_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .push_valid(push_valid), .push_break(push_break), .push_data(push_data),
        .push_ready(push_ready), .pop_req(pop_req), .pop_data(pop_data),
        .level(level), .flag_word(flag_word)
    );

    task automatic compare(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_flags();
        int cnt = sb_q.size();
        return 32'h80 | ((cnt == 16) ? 32'h40 : 0) | ((cnt == 0) ? 32'h10 : 0);
    endfunction

    // one cycle of stimulus, with monitor checks on both sides of the edge
    task automatic step(input bit p, input bit b, input logic [7:0] d, input bit q, input string tag);
        int cnt;
        bit rdy;
        logic [10:0] ent;
        logic [10:0] head;
        @(negedge clk);
        push_valid = p; push_break = b; push_data = d; pop_req = q;
        #1;
        cnt = sb_q.size();
        rdy = fifo_en ? (cnt < 16) : (cnt == 0);
        compare({tag, " ready"}, int'(push_ready), int'(rdy));
        if (q) begin
            head = (cnt > 0) ? sb_q[0] : ref_slot[ref_rd];
            compare({tag, " pop_data"}, int'(pop_data), int'(head));
        end
        @(posedge clk);
        ent = b ? 11'h400 : {3'b000, d};
        if (q && cnt > 0) begin
            void'(sb_q.pop_front());
            ref_rd = (ref_rd + 1) % 16;
        end
        if (p && rdy) begin
            ref_slot[(ref_rd + sb_q.size()) % 16] = ent;
            sb_q.push_back(ent);
        end
        #1;
        compare({tag, " level"}, int'(level), sb_q.size());
        compare({tag, " flags"}, int'(flag_word), exp_flags());
        push_valid = 0; push_break = 0; pop_req = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) ref_slot[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        compare("R1 flags", int'(flag_word), 32'h90);
        compare("R1 level", int'(level), 0);
        compare("R1 ready", int'(push_ready), 1);

        // R9 empty pop right after reset returns zero slot, nothing moves
        step(0, 0, 8'h00, 1, "R9 empty pop");

        // R4 R6 R7 R12 ordered data
        for (int i = 0; i < 5; i++) step(1, 0, 8'hA0 + 8'(i), 0, "R6 push");
        for (int i = 0; i < 5; i++) step(0, 0, 8'h00, 1, "R4 pop");
        step(0, 0, 8'h00, 1, "R7 empty pop");

        // R5 break entry, data ignored
        step(1, 1, 8'hFF, 0, "R5 break push");
        step(0, 0, 8'h00, 1, "R5 break pop");

        // R2 R8 fill all 16 slots across the wrap point
        for (int i = 0; i < 16; i++) step(1, 0, 8'h30 + 8'(i), 0, "R2 fill");
        // R11 dropped push at full
        step(1, 0, 8'hEE, 0, "R11 drop");
        step(1, 1, 8'hEE, 0, "R11 drop brk");
        // R8 pop clears full
        step(0, 0, 8'h00, 1, "R8 pop");
        // R10 push and pop together
        step(1, 0, 8'h5A, 1, "R10 both");
        step(1, 0, 8'h5B, 1, "R10 both");
        for (int i = 0; i < 16; i++) step(0, 0, 8'h00, 1, "R4 drain");
        // R9 stale read after draining: slot at read position
        step(0, 0, 8'h00, 1, "R9 stale");
        step(0, 0, 8'h00, 1, "R9 stale again");

        // R3 holding-register mode
        fifo_en = 1'b0;
        step(1, 0, 8'h77, 0, "R3 first");
        step(1, 0, 8'h78, 0, "R3 second dropped");
        step(0, 0, 8'h00, 1, "R3 pop");
        // R10 push+pop at count 0 in holding mode
        step(1, 0, 8'h79, 1, "R10 hold both");
        step(1, 0, 8'h7A, 1, "R10 hold both busy");
        step(0, 0, 8'h00, 1, "R12 pop");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule